// File: doc/BRIEF.md
# General-Purpose I/O Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port driven through a small word-addressed register interface. Software sets which pins drive and what levels they drive, reads back the levels seen at the pads, and arms a detector on each pin. Each detector can watch for a low level, a high level, a rising edge or a falling edge, or it can watch for any edge.

Every incoming pad level passes through a synchronizer before it is used. A detected condition latches a sticky per-pin flag. Software clears a flag by writing one to its bit. A per-pin enable mask decides which flags reach the single combined interrupt line. Flags latch even on pins whose interrupt is disabled, so software can also poll them.

Reads are combinational from the current address. Writes take effect on the rising clock edge where the write strobe is high.

Top module: `gpio_irq_port`

## Requirements
- R1: Bit n of every port-wide register and port vector belongs to pin n (bit 0 is pin 0). While reset is held, every register reads zero, `padOut`, `padOe` and `irqOut` are zero, and the flag register stays zero.
- R2: The direction register (offset 0x04) drives `padOe` bit for bit: 1 makes the pin an output, 0 makes it an input. It reads back as written.
- R3: A write to the output-level register (offset 0x00) sets all pins' drive levels on `padOut` in the same edge. Reading it returns the levels being driven.
- R4: The pad-level register (offset 0x08) returns `padIn` after a synchronizer of SYNC_STAGES flops, for every pin, whichever way the pin's direction is set.
- R5: Each pin has a 2-bit sensitivity code: 00 = low level, 01 = high level, 10 = rising edge, 11 = falling edge. For pins 0–15 the code sits at bits [2n+1:2n] of offset 0x0C. For pins 16–31 it sits at bits [2(n−16)+1:2(n−16)] of offset 0x10. An edge-coded pin ignores the opposite edge.
- R6: When a pin's any-edge bit (offset 0x1C) is 1, its sensitivity code is ignored and both rising and falling edges latch its flag. A steady level then latches nothing.
- R7: The flag register (offset 0x18) is write-one-to-clear. Writing 0 leaves a bit unchanged. If a detection and a clear reach the same bit in the same cycle, the bit stays set.
- R8: For a level-coded pin whose level is still present, the flag is set again on the edge after it is cleared.
- R9: Flags latch whatever the enable mask (offset 0x14) holds. `irqOut` is high exactly when some pin has both its flag and its enable bit set.
- R10: Writes to the pad-level register (0x08), to a misaligned address or to an address at or above 0x20 change no register. A read of such an unmapped address returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Byte address of the register |
| regWr | input | 1 | Write strobe, taken on the rising edge |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for `regAddr`, combinational |
| padIn | input | 32 | Levels seen at the pads |
| padOut | output | 32 | Levels driven toward the pads |
| padOe | output | 32 | Per-pin output enable |
| irqOut | output | 1 | Combined interrupt |

## Verification
The bench builds the port with its default values: 32 pins, a two-flop synchronizer and a 6-bit address. With these values both sensitivity words are fully populated. Pins in the low word and in the high word (pin 20) can therefore be tested for distinct codes, and the 0x20 hole above the map can be read. The fixed three-edge path from pad to flag is counted into every wait, so the level re-set after a clear, the ignored opposite edge and the any-edge override each show up at the flag register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_W          = 32;
  localparam int SENSE_PER_WORD = REG_W / 2;

  // register selector, taken from address bits [4:2]
  typedef enum logic [2:0] {
    SEL_OUT      = 3'd0,
    SEL_DIR      = 3'd1,
    SEL_PAD      = 3'd2,
    SEL_SENSE_LO = 3'd3,
    SEL_SENSE_HI = 3'd4,
    SEL_MASK     = 3'd5,
    SEL_FLAGS    = 3'd6,
    SEL_ANYEDGE  = 3'd7
  } reg_sel_e;

  localparam logic [1:0] SENSE_LOW  = 2'b00;
  localparam logic [1:0] SENSE_HIGH = 2'b01;
  localparam logic [1:0] SENSE_RISE = 2'b10;
  localparam logic [1:0] SENSE_FALL = 2'b11;

  typedef struct packed {
    logic     wrOut;
    logic     wrDir;
    logic     wrSenseLo;
    logic     wrSenseHi;
    logic     wrMask;
    logic     wrClear;
    logic     wrAnyEdge;
    logic     rdHit;
    reg_sel_e rdSel;
  } gpio_strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  output gpio_strobe_t      stb
);

  logic     mapped;
  logic     wrGo;
  reg_sel_e sel;

  always_comb begin
    mapped = (regAddr[1:0] == 2'b00);
    if (ADDR_W > 5) begin
      mapped = mapped && ((regAddr >> 5) == '0);
    end
    sel  = reg_sel_e'(regAddr[4:2]);
    wrGo = regWr && mapped;

    stb           = '0;
    stb.rdHit     = mapped;
    stb.rdSel     = sel;
    stb.wrOut     = wrGo && (sel == SEL_OUT);
    stb.wrDir     = wrGo && (sel == SEL_DIR);
    stb.wrSenseLo = wrGo && (sel == SEL_SENSE_LO);
    stb.wrSenseHi = wrGo && (sel == SEL_SENSE_HI);
    stb.wrMask    = wrGo && (sel == SEL_MASK);
    stb.wrClear   = wrGo && (sel == SEL_FLAGS);
    stb.wrAnyEdge = wrGo && (sel == SEL_ANYEDGE);
  end

  AST_ONE_WRITE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrOut, stb.wrDir, stb.wrSenseLo, stb.wrSenseHi,
              stb.wrMask, stb.wrClear, stb.wrAnyEdge})); // R10

  AST_PAD_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(8)) |->
      !(stb.wrOut || stb.wrDir || stb.wrSenseLo || stb.wrSenseHi ||
        stb.wrMask || stb.wrClear || stb.wrAnyEdge)); // R10

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpio_strobe_t     stb,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [PINS-1:0]  padIn,
  output logic [PINS-1:0]  padOut,
  output logic [PINS-1:0]  padOe,
  output logic             irqOut
);

  localparam int SENSE_W = 2 * PINS;

  logic [PINS-1:0]    outLevel;
  logic [PINS-1:0]    dirCtl;
  logic [PINS-1:0]    irqEnable;
  logic [PINS-1:0]    irqFlags;
  logic [PINS-1:0]    anyEdge;
  logic [SENSE_W-1:0] senseBits;
  logic [PINS-1:0]    padSync;
  logic [PINS-1:0]    prevSync;
  logic [PINS-1:0]    hitVec;
  logic [PINS-1:0]    clrVec;
  logic [REG_W-1:0]   senseLoWord;
  logic [REG_W-1:0]   senseHiWord;

  // synchronizer chain; the variant follows the stage count
  generate
    if (SYNC_STAGES > 1) begin : g_sync_multi
      logic [SYNC_STAGES-1:0][PINS-1:0] syncStage;
      always_ff @(posedge clk) begin
        if (!rstN) syncStage <= '0;
        else       syncStage <= {syncStage[SYNC_STAGES-2:0], padIn};
      end
      assign padSync = syncStage[SYNC_STAGES-1];
    end else begin : g_sync_single
      logic [PINS-1:0] syncStage;
      always_ff @(posedge clk) begin
        if (!rstN) syncStage <= '0;
        else       syncStage <= padIn;
      end
      assign padSync = syncStage;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) prevSync <= '0;
    else       prevSync <= padSync;
  end

  // per-pin condition detector
  always_comb begin
    for (int n = 0; n < PINS; n++) begin
      if (anyEdge[n]) begin
        hitVec[n] = padSync[n] ^ prevSync[n];
      end else begin
        case (senseBits[2*n +: 2])
          SENSE_LOW:  hitVec[n] = !padSync[n];
          SENSE_HIGH: hitVec[n] = padSync[n];
          SENSE_RISE: hitVec[n] = padSync[n] && !prevSync[n];
          default:    hitVec[n] = !padSync[n] && prevSync[n];
        endcase
      end
    end
  end

  assign clrVec = stb.wrClear ? wrData[PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLevel  <= '0;
      dirCtl    <= '0;
      irqEnable <= '0;
      irqFlags  <= '0;
      anyEdge   <= '0;
      senseBits <= '0;
    end else begin
      if (stb.wrOut)     outLevel  <= wrData[PINS-1:0];
      if (stb.wrDir)     dirCtl    <= wrData[PINS-1:0];
      if (stb.wrMask)    irqEnable <= wrData[PINS-1:0];
      if (stb.wrAnyEdge) anyEdge   <= wrData[PINS-1:0];
      irqFlags <= (irqFlags & ~clrVec) | hitVec;
      for (int n = 0; n < PINS; n++) begin
        if (n < SENSE_PER_WORD) begin
          if (stb.wrSenseLo) senseBits[2*n +: 2] <= wrData[2*(n % SENSE_PER_WORD) +: 2];
        end else begin
          if (stb.wrSenseHi) senseBits[2*n +: 2] <= wrData[2*(n % SENSE_PER_WORD) +: 2];
        end
      end
    end
  end

  always_comb begin
    senseLoWord = '0;
    senseHiWord = '0;
    for (int n = 0; n < PINS; n++) begin
      if (n < SENSE_PER_WORD) senseLoWord[2*(n % SENSE_PER_WORD) +: 2] = senseBits[2*n +: 2];
      else                    senseHiWord[2*(n % SENSE_PER_WORD) +: 2] = senseBits[2*n +: 2];
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdHit) begin
      case (stb.rdSel)
        SEL_OUT:      rdData = REG_W'(outLevel);
        SEL_DIR:      rdData = REG_W'(dirCtl);
        SEL_PAD:      rdData = REG_W'(padSync);
        SEL_SENSE_LO: rdData = senseLoWord;
        SEL_SENSE_HI: rdData = senseHiWord;
        SEL_MASK:     rdData = REG_W'(irqEnable);
        SEL_FLAGS:    rdData = REG_W'(irqFlags);
        default:      rdData = REG_W'(anyEdge);
      endcase
    end
  end

  assign padOut = outLevel;
  assign padOe  = dirCtl;
  assign irqOut = |(irqFlags & irqEnable);

  AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrOut |=> (padOut == $past(wrData[PINS-1:0]))); // R3

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrClear |=> ((irqFlags & $past(wrData[PINS-1:0] & ~hitVec)) == '0)); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrClear |=> ((irqFlags & $past(irqFlags)) == $past(irqFlags))); // R7

  AST_ANY_EDGE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (((padSync ^ prevSync) & anyEdge) != '0) |=>
      ((irqFlags & $past((padSync ^ prevSync) & anyEdge)) ==
        $past((padSync ^ prevSync) & anyEdge))); // R6

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnable == '0) |-> !irqOut); // R9

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdHit |-> (rdData == '0)); // R10

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int PINS        = 32,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWData,
  output logic [REG_W-1:0]  regRData,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic              irqOut
);

  gpio_strobe_t stb;

  gpio_port_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWr   (regWr),
    .stb     (stb)
  );

  gpio_port_datapath #(.PINS(PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wrData (regWData),
    .rdData (regRData),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .irqOut (irqOut)
  );

endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic        irqOut;

  int runCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWData(regWData), .regRData(regRData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isWr;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  // register round trips: R2 direction, R3 output, R5 sense words,
  // R9 mask, R6 any-edge, R10 unmapped read
  localparam int NVEC = 15;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 6'h04, 32'hF0F0F0F0, 8'd2},
    '{1'b0, 6'h04, 32'hF0F0F0F0, 8'd2},
    '{1'b1, 6'h00, 32'h12345678, 8'd3},
    '{1'b0, 6'h00, 32'h12345678, 8'd3},
    '{1'b1, 6'h0C, 32'hA5A5A5A5, 8'd5},
    '{1'b0, 6'h0C, 32'hA5A5A5A5, 8'd5},
    '{1'b1, 6'h10, 32'h0F0F0F0F, 8'd5},
    '{1'b0, 6'h10, 32'h0F0F0F0F, 8'd5},
    '{1'b1, 6'h14, 32'h0000FFFF, 8'd9},
    '{1'b0, 6'h14, 32'h0000FFFF, 8'd9},
    '{1'b1, 6'h1C, 32'h00000001, 8'd6},
    '{1'b0, 6'h1C, 32'h00000001, 8'd6},
    '{1'b0, 6'h20, 32'h00000000, 8'd10},
    '{1'b1, 6'h14, 32'h00000000, 8'd9},
    '{1'b1, 6'h1C, 32'h00000000, 8'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdCheck(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(req, regRData, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    regAddr = 6'h18; #1;
    check("R1 flags in reset", regRData, 32'h0);
    check("R1 padOut in reset", padOut, 32'h0);
    check("R1 padOe in reset", padOe, 32'h0);
    check("R1 irq in reset", {31'h0, irqOut}, 32'h0);
    regAddr = 6'h04; #1;
    check("R1 dir in reset", regRData, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].isWr) wrReg(VEC[i].addr, VEC[i].data);
      else             rdCheck(VEC[i].addr, VEC[i].data, $sformatf("R%0d vector %0d", VEC[i].req, i));
    end
    check("R2 padOe follows direction", padOe, 32'hF0F0F0F0);
    check("R3 padOut follows output level", padOut, 32'h12345678);

    // R8: reset leaves all pins low-level coded with low pads; clear, flags return
    wrReg(6'h0C, 32'h0);
    wrReg(6'h10, 32'h0);
    wrReg(6'h18, 32'hFFFFFFFF);
    rdCheck(6'h18, 32'hFFFFFFFF, "R8 low level re-sets after clear");

    // R5 high-level everywhere
    wrReg(6'h0C, 32'h55555555);
    wrReg(6'h10, 32'h55555555);
    wrReg(6'h18, 32'hFFFFFFFF);
    rdCheck(6'h18, 32'h0, "R5 high level idle");
    padIn = 32'h8; settle();
    rdCheck(6'h18, 32'h8, "R5 high level pin3");
    check("R9 masked flag keeps irq low", {31'h0, irqOut}, 32'h0);
    rdCheck(6'h08, 32'h8, "R4 pad level pin3");

    wrReg(6'h14, 32'h8);
    check("R9 enabled flag raises irq", {31'h0, irqOut}, 32'h1);
    wrReg(6'h18, 32'h0);
    rdCheck(6'h18, 32'h8, "R7 write zero keeps flag");
    wrReg(6'h18, 32'h8);
    rdCheck(6'h18, 32'h8, "R8 high level re-sets after clear");
    wrReg(6'h14, 32'h0);
    check("R9 disabled mask drops irq", {31'h0, irqOut}, 32'h0);

    // R5 rising edge on pin5
    wrReg(6'h0C, 32'h55555955);
    padIn = padIn | 32'h20; settle();
    rdCheck(6'h18, 32'h28, "R5 rising edge pin5");
    wrReg(6'h18, 32'h20);
    rdCheck(6'h18, 32'h08, "R7 clear one bit");
    padIn = padIn & ~32'h20; settle();
    rdCheck(6'h18, 32'h08, "R5 rising ignores falling");

    // R5 falling edge on pin20 (high sense word)
    wrReg(6'h10, 32'h55555755);
    padIn = padIn | 32'h00100000; settle();
    rdCheck(6'h18, 32'h08, "R5 falling ignores rising");
    padIn = padIn & ~32'h00100000; settle();
    rdCheck(6'h18, 32'h00100008, "R5 falling edge pin20");
    wrReg(6'h18, 32'h00100000);
    rdCheck(6'h18, 32'h08, "R7 clear pin20");

    // R6 any-edge on pin7 overrides its high-level code
    wrReg(6'h1C, 32'h80);
    padIn = padIn | 32'h80; settle();
    rdCheck(6'h18, 32'h88, "R6 any edge rising pin7");
    rdCheck(6'h08, 32'h88, "R4 pad level on output pin7");
    wrReg(6'h18, 32'h80);
    rdCheck(6'h18, 32'h08, "R6 steady level ignored");
    padIn = padIn & ~32'h80; settle();
    rdCheck(6'h18, 32'h88, "R6 any edge falling pin7");

    // R10 pad-level register is read-only
    wrReg(6'h08, 32'hFFFFFFFF);
    rdCheck(6'h08, 32'h08, "R10 pad write ignored");
    rdCheck(6'h04, 32'hF0F0F0F0, "R10 pad write leaves direction");
    wrReg(6'h21, 32'hFFFFFFFF);
    rdCheck(6'h00, 32'h12345678, "R10 unmapped write ignored");

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      runCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

endmodule